// File: doc/BRIEF.md
# Folded-Octant Phase Evaluator

This block turns a pair of signed correlation results into a phase angle. The in-phase accumulator (the cosine product sum, called x below) and the quadrature accumulator (the sine product sum, called y below) are presented together with a one-cycle start strobe. The block works out the angle atan2(y, x) without a full-circle arctangent table.

It first folds the pair into the first octant. It divides the smaller magnitude by the larger with a sequential restoring divider, which gives a 12-bit fraction between 0 and 1. That fraction becomes an offset between 0 and 45 degrees. Small fractions take a linear shortcut, and larger ones take a 64-entry table that is built at elaboration. The block then rebuilds the full-circle phase from the two signs and from which magnitude is larger.

The result is given in units of 1/64 degree, in the range 0 to 360 degrees exclusive, together with a one-cycle valid pulse. A flag marks the case where both inputs are zero and the angle is undefined. Each evaluation takes a fixed number of cycles, and only one is in flight at a time.

Top module: `phase_octant_eval`

## Requirements
- R1: While reset is asserted and after it is released, `phase_vld_o` and `nodir_o` are 0 and `phase_o` is 0.
- R2: A start that is sampled while the block is idle is accepted. Its result appears with `phase_vld_o` high for exactly one cycle, Q_W+2 (14) clock edges after the accepting edge. The next start can be accepted on the edge after the pulse.
- R3: A start that is sampled on any edge from the accepting edge +1 through +14 is ignored. The result delivered still belongs to the operands that were accepted.
- R4: The fold ratio q is floor(min(|x|,|y|)·4096 / max(|x|,|y|)). It is exact for any 24-bit two's-complement input, including -8388608.
- R5: If q < 512 (ratio below 1/8), the offset is (q·3667 + 2048) >> 12, in units of 1/64 degree.
- R6: If q ≥ 512, the offset is round(atan((k + 0.5)/64)·(180/π)·64), where k = q >> 6 (the upper 6 bits of q).
- R7: Equal nonzero magnitudes give an offset of exactly 2880 (45°). Offsets never exceed 2880.
- R8: If |y| > |x| strictly, the in-quadrant angle is 5760 − offset. Otherwise it is the offset.
- R9: Let b be the in-quadrant angle, and treat an input of zero as non-negative. The phase is then: b for x≥0 and y≥0; 11520 − b for x<0 and y≥0; 11520 + b for x<0 and y<0; 23040 − b for x≥0 and y<0, or 0 when b is 0 in that last case. `phase_o` is always below 23040.
- R10: If both inputs are zero, the result is `phase_o` = 0 with `nodir_o` = 1. For any other input, `nodir_o` = 0 with the result.
- R11: For nonzero inputs, `phase_o`/64 is within 0.5° of atan2(y, x) taken into [0°, 360°), with the wrap at 0°/360° taken into account.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| cos_acc_i | input | IN_W (24) | In-phase accumulator x, signed |
| sin_acc_i | input | IN_W (24) | Quadrature accumulator y, signed |
| phase_vld_o | output | 1 | One-cycle result valid pulse |
| phase_o | output | PH_W (16) | Phase in 1/64 degree, range [0, 23040) |
| nodir_o | output | 1 | Both inputs were zero, so the angle is undefined |

## Verification
The hardest situations to reach from the ports are a start that lands on the very edge where the previous result is still pending, and a start on the first edge where the block is free again. A held start strobe with operands that change every cycle drives the block into both. The other hard cases are the seams between paths: the last linear fraction (q = 511) against the first table entry (q = 512), and the wrap of the fourth quadrant back to zero for tiny negative y. Operand pairs are chosen arithmetically to hit these exactly, and an angle sweep through all eight octants compares each result with a floating-point arctangent.

// File: rtl/poe_pkg.sv
package poe_pkg;

  localparam real PI_R = 3.14159265358979323846;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_OUT  = 2'd2
  } poe_state_e;

  // Sign and size relation of the captured operands
  typedef struct packed {
    logic neg_x;    // in-phase operand negative
    logic neg_y;    // quadrature operand negative
    logic y_major;  // |y| strictly larger than |x|
    logic eq;       // equal nonzero magnitudes
    logic zero;     // both operands zero
  } poe_octant_t;

  // Radians-to-degree gain in units of 2^-frac degree, rounded
  function automatic int lin_gain(input int frac);
    return int'((180.0 / PI_R) * (2.0 ** frac));
  endfunction

  // Arctangent sampled at the midpoint of bin idx out of 2^idx_w, degree units 2^-frac
  function automatic int atan_entry(input int idx, input int idx_w, input int frac);
    real r;
    r = (real'(idx) + 0.5) / (2.0 ** idx_w);
    return int'($atan(r) * (180.0 / PI_R) * (2.0 ** frac));
  endfunction

endpackage

// File: rtl/poe_restoring_div.sv
module poe_restoring_div #(
  parameter int MAG_W = 24,
  parameter int Q_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MAG_W-1:0] num,
  input  logic [MAG_W-1:0] den,
  output logic             done,
  output logic [Q_W-1:0]   quo
);

  localparam int CNT_W = $clog2(Q_W + 1);

  logic [MAG_W-1:0] rem_q;
  logic [MAG_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  logic [MAG_W:0]   rem_sh;
  logic             fits;
  logic [MAG_W:0]   rem_nx;

  // One restoring step: shift, trial subtract, keep or restore
  always_comb begin
    rem_sh = {rem_q, 1'b0};
    fits   = (rem_sh >= {1'b0, den_q});
    rem_nx = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
      quo   <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        rem_q <= num;
        den_q <= den;
        cnt_q <= CNT_W'(Q_W);
        run_q <= 1'b1;
        quo   <= '0;
      end else if (run_q) begin
        rem_q <= rem_nx[MAG_W-1:0];
        quo   <= {quo[Q_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/poe_atan_fold.sv
module poe_atan_fold #(
  parameter int Q_W       = 12,
  parameter int IDX_W     = 6,
  parameter int LIN_SHIFT = 3,
  parameter int DEG_FRAC  = 6,
  parameter int OFF_W     = 13
) (
  input  logic [Q_W-1:0]   quo,
  input  logic             eq,
  output logic [OFF_W-1:0] offset
);

  localparam int LIN_K  = poe_pkg::lin_gain(DEG_FRAC);
  localparam int KW     = $clog2(LIN_K + 1);
  localparam int PW     = Q_W + KW + 1;
  localparam int HALF45 = 45 << DEG_FRAC;
  localparam int NLUT   = 2 ** IDX_W;

  logic [OFF_W-1:0] lut [NLUT];

  // Octant table, one entry per bin midpoint, computed at elaboration
  for (genvar g = 0; g < NLUT; g++) begin : g_lut
    localparam int ENTRY = poe_pkg::atan_entry(g, IDX_W, DEG_FRAC);
    assign lut[g] = OFF_W'(ENTRY);
  end

  logic             small_ratio;
  logic [PW-1:0]    lin_prod;
  logic [PW-1:0]    lin_rnd;
  logic [IDX_W-1:0] idx;

  always_comb begin
    small_ratio = (quo[Q_W-1 -: LIN_SHIFT] == '0);
    lin_prod    = PW'(quo) * PW'(LIN_K);
    lin_rnd     = (lin_prod + PW'(1 << (Q_W - 1))) >> Q_W;
    idx         = quo[Q_W-1 -: IDX_W];
    if (eq)               offset = OFF_W'(HALF45);
    else if (small_ratio) offset = OFF_W'(lin_rnd);
    else                  offset = lut[idx];
  end

endmodule

// File: rtl/poe_quadrant.sv
module poe_quadrant
  import poe_pkg::*;
#(
  parameter int OFF_W    = 13,
  parameter int PH_W     = 16,
  parameter int DEG_FRAC = 6
) (
  input  logic [OFF_W-1:0] offset,
  input  poe_octant_t      oct,
  output logic [PH_W-1:0]  phase
);

  localparam logic [PH_W-1:0] D90  = PH_W'(90  << DEG_FRAC);
  localparam logic [PH_W-1:0] D180 = PH_W'(180 << DEG_FRAC);
  localparam logic [PH_W-1:0] D360 = PH_W'(360 << DEG_FRAC);

  // Unfold an octant offset into the full circle
  function automatic logic [PH_W-1:0] unfold(input logic [OFF_W-1:0] off,
                                             input poe_octant_t o);
    logic [PH_W-1:0] b;
    b = o.y_major ? (D90 - PH_W'(off)) : PH_W'(off);
    if (o.zero) return '0;
    case ({o.neg_x, o.neg_y})
      2'b00:   return b;
      2'b10:   return D180 - b;
      2'b11:   return D180 + b;
      default: return (b == '0) ? '0 : (D360 - b);
    endcase
  endfunction

  assign phase = unfold(offset, oct);

endmodule

// File: rtl/phase_octant_eval.sv
module phase_octant_eval
  import poe_pkg::*;
#(
  parameter int IN_W      = 24,
  parameter int Q_W       = 12,
  parameter int IDX_W     = 6,
  parameter int LIN_SHIFT = 3,
  parameter int DEG_FRAC  = 6,
  parameter int PH_W      = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic signed [IN_W-1:0] cos_acc_i,
  input  logic signed [IN_W-1:0] sin_acc_i,
  output logic                   phase_vld_o,
  output logic [PH_W-1:0]        phase_o,
  output logic                   nodir_o
);

  localparam int OFF_W = $clog2((90 << DEG_FRAC) + 1);

  function automatic logic [IN_W-1:0] mag_of(input logic [IN_W-1:0] v);
    return v[IN_W-1] ? (~v + 1'b1) : v;
  endfunction

  poe_state_e       state_q;
  poe_octant_t      oct_q;
  poe_octant_t      oct_in;
  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] off_nx;
  logic [PH_W-1:0]  phase_nx;
  logic [IN_W-1:0]  mag_x, mag_y, div_num, div_den;
  logic             div_done;
  logic [Q_W-1:0]   div_quo;

  // Named events for the checker
  logic start_acc;
  logic off_vld;
  logic out_fire;

  assign start_acc = start_i && (state_q == ST_IDLE);
  assign off_vld   = (state_q == ST_DIV) && div_done;
  assign out_fire  = (state_q == ST_OUT);

  always_comb begin
    mag_x          = mag_of(cos_acc_i);
    mag_y          = mag_of(sin_acc_i);
    oct_in.neg_x   = cos_acc_i[IN_W-1];
    oct_in.neg_y   = sin_acc_i[IN_W-1];
    oct_in.y_major = (mag_y > mag_x);
    oct_in.zero    = (mag_x == '0) && (mag_y == '0);
    oct_in.eq      = (mag_x == mag_y) && !oct_in.zero;
    div_num        = oct_in.y_major ? mag_x : mag_y;
    div_den        = oct_in.y_major ? mag_y : mag_x;
  end

  poe_restoring_div #(
    .MAG_W (IN_W),
    .Q_W   (Q_W)
  ) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_acc),
    .num   (div_num),
    .den   (div_den),
    .done  (div_done),
    .quo   (div_quo)
  );

  poe_atan_fold #(
    .Q_W       (Q_W),
    .IDX_W     (IDX_W),
    .LIN_SHIFT (LIN_SHIFT),
    .DEG_FRAC  (DEG_FRAC),
    .OFF_W     (OFF_W)
  ) fold_i (
    .quo    (div_quo),
    .eq     (oct_q.eq),
    .offset (off_nx)
  );

  poe_quadrant #(
    .OFF_W    (OFF_W),
    .PH_W     (PH_W),
    .DEG_FRAC (DEG_FRAC)
  ) quad_i (
    .offset (off_q),
    .oct    (oct_q),
    .phase  (phase_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      oct_q       <= '0;
      off_q       <= '0;
      phase_vld_o <= 1'b0;
      phase_o     <= '0;
      nodir_o     <= 1'b0;
    end else begin
      phase_vld_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_acc) begin
          oct_q   <= oct_in;
          state_q <= ST_DIV;
        end
        ST_DIV: if (off_vld) begin
          off_q   <= off_nx;
          state_q <= ST_OUT;
        end
        default: begin
          phase_o     <= phase_nx;
          nodir_o     <= oct_q.zero;
          phase_vld_o <= out_fire;
          state_q     <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/poe_chk.sv
module poe_chk #(
  parameter int Q_W      = 12,
  parameter int PH_W     = 16,
  parameter int OFF_W    = 13,
  parameter int DEG_FRAC = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_acc,
  input logic             phase_vld_o,
  input logic             nodir_o,
  input logic [PH_W-1:0]  phase_o,
  input logic             off_vld,
  input logic [OFF_W-1:0] off_q
);

  localparam int LAT = Q_W + 2;

  int lat_cnt;

  // Independent count of edges since the last accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             lat_cnt <= 0;
    else if (start_acc)                     lat_cnt <= 1;
    else if (lat_cnt != 0 && lat_cnt <= LAT) lat_cnt <= lat_cnt + 1;
    else                                    lat_cnt <= 0;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_vld_o |-> (lat_cnt == LAT + 1));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_vld_o |=> !phase_vld_o);

  assert_busy_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |-> (lat_cnt == 0 || lat_cnt > LAT));

  assert_offset_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    off_vld |=> (off_q <= OFF_W'(45 << DEG_FRAC)));

  assert_phase_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    phase_vld_o |-> (phase_o < PH_W'(360 << DEG_FRAC)));

  assert_nodir_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld_o && nodir_o) |-> (phase_o == '0));

endmodule

bind phase_octant_eval poe_chk #(
  .Q_W      (Q_W),
  .PH_W     (PH_W),
  .OFF_W    (OFF_W),
  .DEG_FRAC (DEG_FRAC)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_acc   (start_acc),
  .phase_vld_o (phase_vld_o),
  .nodir_o     (nodir_o),
  .phase_o     (phase_o),
  .off_vld     (off_vld),
  .off_q       (off_q)
);

// File: tb/phase_octant_eval_tb_top.sv
module phase_octant_eval_tb_top;

  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic signed [23:0] ci, si;
  logic        vld;
  logic [15:0] ph;
  logic        nodir;
  bit          running;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  phase_octant_eval dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .cos_acc_i   (ci),
    .sin_acc_i   (si),
    .phase_vld_o (vld),
    .phase_o     (ph),
    .nodir_o     (nodir)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Behavioural phase expectation, straight from the requirements
  function automatic void ref_phase(input longint x, input longint y,
                                    output int p, output bit fl, output string tag);
    longint ax, ay, mn, mx, q;
    int off, b;
    ax = (x < 0) ? -x : x;
    ay = (y < 0) ? -y : y;
    fl = 0;
    if (ax == 0 && ay == 0) begin
      p = 0; fl = 1; tag = "R10"; return;
    end
    mn = (ax < ay) ? ax : ay;
    mx = (ax < ay) ? ay : ax;
    if (mn == mx) begin
      off = 2880; tag = "R7";
    end else begin
      q = (mn * 4096) / mx;
      if (q < 512) begin
        off = int'((q * 3667 + 2048) / 4096); tag = "R5 R4";
      end else begin
        off = int'($atan((real'(q / 64) + 0.5) / 64.0) * 180.0 / PI * 64.0);
        tag = "R6 R4";
      end
    end
    b = (ay > ax) ? 5760 - off : off;   // R8
    if (x >= 0 && y >= 0)      p = b;   // R9
    else if (x < 0 && y >= 0)  p = 11520 - b;
    else if (x < 0)            p = 11520 + b;
    else                       p = (b == 0) ? 0 : 23040 - b;
  endfunction

  // Cycle-level reference model
  bit     m_busy;
  int     m_left;
  longint m_x, m_y;
  int     m_ph;
  bit     m_fl;
  string  m_tag;
  bit     e_vld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_left = 0; e_vld = 0;
    end else begin
      e_vld = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; e_vld = 1;
        end
      end else if (start) begin
        m_x = ci; m_y = si;
        ref_phase(m_x, m_y, m_ph, m_fl, m_tag);
        m_busy = 1; m_left = 14;
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      check(vld == e_vld, "R2 R3", "valid", vld, e_vld);
      if (e_vld) begin
        real refd, d;
        check(int'(ph) == m_ph, m_tag, "phase R8 R9", ph, m_ph);
        check(nodir == m_fl, "R10", "nodir", nodir, m_fl);
        if (!m_fl) begin
          refd = $atan2(real'(m_y), real'(m_x)) * 180.0 / PI;
          if (refd < 0.0) refd += 360.0;
          d = real'(ph) / 64.0 - refd;
          if (d > 180.0) d -= 360.0;
          if (d < -180.0) d += 360.0;
          if (d < 0.0) d = -d;
          check(d <= 0.5, "R11", "error mdeg", longint'(d * 1000.0), 500);
        end
      end
    end
  end

  task automatic op(input longint x, input longint y);
    @(negedge clk);
    ci = 24'(x); si = 24'(y); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (15) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R2: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; ci = '0; si = '0; running = 0;
    repeat (3) @(negedge clk);
    // R1: reset state while held and right after release
    check(vld == 1'b0 && nodir == 1'b0, "R1", "flags in reset", {vld, nodir}, 0);
    check(ph == '0, "R1", "phase in reset", ph, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vld == 1'b0 && ph == '0, "R1", "after release", ph, 0);
    running = 1;

    // Sweep through all eight octants (R9, R11)
    for (int k = 0; k < 48; k++) begin
      real a;
      a = (real'(k) * 7.5 + 1.3) * PI / 180.0;
      op(longint'(1000000.0 * $cos(a)), longint'(1000000.0 * $sin(a)));
    end

    // Axes and zero (R9, R10)
    op(0, 0);
    op(1000, 0);
    op(0, 5000);
    op(-7, 0);
    op(0, -1);
    // Equal magnitudes in every quadrant (R7)
    op(3000, 3000);
    op(-3000, 3000);
    op(-3000, -3000);
    op(3000, -3000);
    // Most negative operand (R4)
    op(-8388608, 0);
    op(-8388608, -8388608);
    op(5, -8388608);
    op(8388607, -8388608);
    // Linear/table seam: q = 511 then q = 512 (R5, R6)
    op(800000, 99999);
    op(800000, 100000);
    op(-100000, 800000);
    // Tiny ratios and fourth-quadrant wrap to zero (R5, R9)
    op(8000000, 1);
    op(8000000, -1);
    op(-1, -2);
    op(2, -1);

    // R3: a second start while busy is ignored
    @(negedge clk);
    ci = 24'sd400000; si = 24'sd123456; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    ci = -24'sd5; si = 24'sd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (16) @(negedge clk);

    // R2/R3: start held high, operands change every cycle
    for (int c = 0; c < 45; c++) begin
      @(negedge clk);
      start = 1'b1;
      ci = 24'(c * 1000 - 17000);
      si = 24'(30000 - c * 1500);
    end
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule